// File: doc/BRIEF.md
# Byte-Serial Recirculating Shift Memory

This block is a serial storage memory that holds bytes of nine bits in nine parallel circulating loops. All loops advance together, so every shift step moves one whole byte from the tail of the storage towards the output. In the same step, a byte goes into the head. With the default parameters the loop holds 1024 bytes. Each loop is built from segments of 128 stages. Every segment ends in a regeneration stage that feeds the next segment, and the last regeneration stage is the tail of the loop.

A step happens on each rising clock edge at which `shift_en` is high. Between edges, the tail byte is available on `dq_out`. At the edge, the head stage takes one of two values: the tail byte itself (recirculate) or the byte on `dq_in` (write). Which one it takes depends on the two active-low controls and the data-enable input. The bidirectional data bus is split into an input port, an output port and an output enable. The output enable lets several devices share one wired bus.

When data-enable is low, the read and write controls have no effect. The loops then only recirculate, which suits search passes and standby.

Top module: `serial_byte_loop`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every stored byte is zero, `dq_out` is 0 and `dq_oe` is 0.
- R2: At an edge where `shift_en` is 0, neither the stored contents nor `dq_out` change, whatever the levels of `de`, `rd_n`, `wr_n` and `dq_in`.
- R3: A byte that enters the head at step s is presented on `dq_out` during step s+1024 (DEPTH steps later). After DEPTH steps with no writes, every byte is back in its original position.
- R4: Recirculate mode (`de`=1, `rd_n`=1, `wr_n`=1): the head takes the tail byte and `dq_oe` is 0.
- R5: Read mode (`de`=1, `rd_n`=0, `wr_n`=1): `dq_oe` is 1, `dq_out` shows the tail byte, and the head takes that same byte, so reading does not destroy the data.
- R6: Write mode (`de`=1, `rd_n`=1, `wr_n`=0): the head takes `dq_in` and `dq_oe` is 0.
- R7: Read-modify-write mode (`de`=1, `rd_n`=0, `wr_n`=0): `dq_oe` is 1, `dq_out` shows the old tail byte during the step, and the value of `dq_in` sampled at the end of the step becomes the new head byte.
- R8: With `de`=0, `rd_n` and `wr_n` are ignored: the head takes the tail byte and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | One shift step at each edge where this is high |
| de | input | 1 | Data enable; low forces recirculation |
| rd_n | input | 1 | Active-low read control |
| wr_n | input | 1 | Active-low write control |
| dq_in | input | 9 | Incoming side of the data bus |
| dq_out | output | 9 | Outgoing side of the data bus (tail byte) |
| dq_oe | output | 1 | Output enable for the data bus driver |

## Verification
The hardest thing to reach from the ports is a byte returning to the output through all eight segments and their regeneration stages. This happens only 1024 steps after the byte was written, so every ordering error at a segment boundary stays hidden until then. The bench writes a full loop of distinct bytes. It then runs complete passes in each mode: recirculate, disabled with both controls asserted, read, read-modify-write with data derived from the old byte, and a final read. A model of the loop, indexed by step count modulo the depth, predicts every tail byte in every pass. Idle cycles with the write control asserted are inserted between passes, which shows that a missing shift step has no effect.

// File: rtl/serial_byte_loop_pkg.sv
// Package: shared mode type for the byte-serial loop memory.
// Assumes: controls are active low, and data enable gates them.
package serial_byte_loop_pkg;

    typedef enum logic [1:0] {
        MODE_RECIRC = 2'd0,
        MODE_READ   = 2'd1,
        MODE_WRITE  = 2'd2,
        MODE_RMW    = 2'd3
    } loop_mode_t;

    // Map the three control levels onto an operating mode.
    function automatic loop_mode_t decode_mode(input logic de, input logic rd_n, input logic wr_n);
        if (!de)                  return MODE_RECIRC;
        else if (!rd_n && !wr_n)  return MODE_RMW;
        else if (!wr_n)           return MODE_WRITE;
        else if (!rd_n)           return MODE_READ;
        else                      return MODE_RECIRC;
    endfunction

endpackage

// File: rtl/serial_byte_loop_ctrl.sv
// Module: serial_byte_loop_ctrl
// Turns the data enable and the active-low controls into two decisions:
// whether the bus is driven, and whether the head takes bus data.
// Assumes: the decisions are used at the step edge; purely combinational.
module serial_byte_loop_ctrl
    import serial_byte_loop_pkg::*;
(
    input  logic       de,
    input  logic       rd_n,
    input  logic       wr_n,
    output loop_mode_t mode,
    output logic       drive_bus,
    output logic       load_bus
);

    // Decode the mode and derive the output and head-select controls.
    always_comb begin
        mode      = decode_mode(de, rd_n, wr_n);
        drive_bus = (mode == MODE_READ) || (mode == MODE_RMW);
        load_bus  = (mode == MODE_WRITE) || (mode == MODE_RMW);
    end

endmodule

// File: rtl/serial_byte_loop_ptr.sv
// Module: serial_byte_loop_ptr
// Shared rotating index into the storage of every segment. It advances once
// per step and wraps after SLOTS positions.
// Assumes: SLOTS >= 2.
module serial_byte_loop_ptr #(
    parameter int SLOTS = 127,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

    // Advance the index on each step and wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/serial_byte_loop_seg.sv
// Module: serial_byte_loop_seg
// One segment of the loop: SEG_LEN-1 byte slots used as a circular delay
// line, followed by a regeneration register. The delay from input to output
// is SEG_LEN steps.
// Assumes: the index comes from the shared pointer and wraps at SEG_LEN-1.
module serial_byte_loop_seg #(
    parameter int WIDTH   = 9,
    parameter int SEG_LEN = 128,
    localparam int SLOTS  = SEG_LEN - 1,
    localparam int PTR_W  = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [PTR_W-1:0] ptr,
    input  logic [WIDTH-1:0] seg_in,
    output logic [WIDTH-1:0] seg_out
);

    logic [WIDTH-1:0] slots_q [SLOTS];

    // Move the oldest slot into the regeneration stage and store the new byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++)
                slots_q[i] <= '0;
            seg_out <= '0;
        end else if (step) begin
            seg_out      <= slots_q[ptr];
            slots_q[ptr] <= seg_in;
        end
    end

endmodule

// File: rtl/serial_byte_loop.sv
// Module: serial_byte_loop (top)
// A byte-serial recirculating memory of DEPTH bytes of WIDTH bits. The loops
// are chained segments of SEG_LEN stages. The tail byte is presented on the
// bus, and at each step the head takes either that byte or the bus input.
// Assumes: DEPTH is a multiple of SEG_LEN, and SEG_LEN >= 3.
module serial_byte_loop
    import serial_byte_loop_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int DEPTH   = 1024,
    parameter int SEG_LEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             de,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] dq_in,
    output logic [WIDTH-1:0] dq_out,
    output logic             dq_oe
);

    localparam int NSEG  = DEPTH / SEG_LEN;
    localparam int SLOTS = SEG_LEN - 1;
    localparam int PTR_W = $clog2(SLOTS);

    loop_mode_t       mode;
    logic             drive_bus;
    logic             load_bus;
    logic [PTR_W-1:0] seg_ptr;
    logic [WIDTH-1:0] link [NSEG+1];

    serial_byte_loop_ctrl u_ctrl (
        .de        (de),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .mode      (mode),
        .drive_bus (drive_bus),
        .load_bus  (load_bus)
    );

    serial_byte_loop_ptr #(.SLOTS(SLOTS)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (shift_en),
        .ptr   (seg_ptr)
    );

    // Head select: bus data in write modes, the recirculated tail otherwise.
    always_comb link[0] = load_bus ? dq_in : link[NSEG];

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        serial_byte_loop_seg #(.WIDTH(WIDTH), .SEG_LEN(SEG_LEN)) u_seg (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (shift_en),
            .ptr     (seg_ptr),
            .seg_in  (link[k]),
            .seg_out (link[k+1])
        );
    end

    // Present the tail byte and qualify it with the bus enable.
    always_comb begin
        dq_out = link[NSEG];
        dq_oe  = drive_bus;
    end

endmodule

// File: rtl/serial_byte_loop_chk.sv
// Module: serial_byte_loop_chk
// Property checker for serial_byte_loop, attached by the bind below.
// Assumes: it sees the top's ports and its shared segment pointer.
module serial_byte_loop_chk #(
    parameter int WIDTH   = 9,
    parameter int SEG_LEN = 128,
    localparam int SLOTS  = SEG_LEN - 1,
    localparam int PTR_W  = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic             de,
    input logic             rd_n,
    input logic             wr_n,
    input logic [WIDTH-1:0] dq_out,
    input logic             dq_oe,
    input logic [PTR_W-1:0] seg_ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

    p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dq_out));

    p_hold_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(seg_ptr));

    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && seg_ptr == LAST) |=> (seg_ptr == '0));

    p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ptr <= LAST);

    p_no_drive_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (de && rd_n && !wr_n) |-> !dq_oe);

    p_drive_rmw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de && !rd_n && !wr_n) |-> dq_oe);

    p_no_drive_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> !dq_oe);

endmodule

bind serial_byte_loop serial_byte_loop_chk #(.WIDTH(WIDTH), .SEG_LEN(SEG_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .de       (de),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .seg_ptr  (seg_ptr)
);

// File: tb/serial_byte_loop_tb.sv
`timescale 1ns/1ps
module serial_byte_loop_tb;

    localparam int WIDTH = 9;
    localparam int DEPTH = 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             shift_en = 1'b0;
    logic             de = 1'b0;
    logic             rd_n = 1'b1;
    logic             wr_n = 1'b1;
    logic [WIDTH-1:0] dq_in = '0;
    logic [WIDTH-1:0] dq_out;
    logic             dq_oe;

    int errs = 0;
    int checks = 0;
    int sidx = 0;
    logic [WIDTH-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    serial_byte_loop u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .de       (de),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check before the rising edge, update the model.
    task automatic cyc(input string req, input logic en, input logic de_i, input logic rd_i,
                       input logic wr_i, input logic [WIDTH-1:0] d);
        logic [WIDTH-1:0] tail;
        @(negedge clk);
        shift_en = en; de = de_i; rd_n = rd_i; wr_n = wr_i; dq_in = d;
        #1;
        tail = model[sidx];
        chk(req, dq_out, tail);
        chk(req, {8'd0, dq_oe}, {8'd0, de_i && !rd_i});
        if (en) begin
            model[sidx] = (de_i && !wr_i) ? d : tail;
            sidx = (sidx + 1) % DEPTH;
        end
        @(posedge clk);
    endtask

    initial begin
        #(150000 * 5);
        errs++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset out", dq_out, '0);
        chk("R1 reset oe", {8'd0, dq_oe}, 9'd0);
        // R6 write a full loop of distinct bytes; tail shows reset zeros (R1)
        for (int i = 0; i < DEPTH; i++)
            cyc("R6 write", 1'b1, 1'b1, 1'b1, 1'b0, WIDTH'((i * 37 + 5) & 511));
        // R4 recirculate one full loop; R3 the pattern returns after DEPTH steps
        for (int i = 0; i < DEPTH; i++)
            cyc("R4 recirc", 1'b1, 1'b1, 1'b1, 1'b1, '0);
        // R2 no step while shift_en is low, even with write asserted
        for (int i = 0; i < 8; i++)
            cyc("R2 hold", 1'b0, 1'b1, 1'b1, 1'b0, 9'h1FF);
        // R8 data enable low: both controls asserted but ignored
        for (int i = 0; i < DEPTH; i++)
            cyc("R8 disabled", 1'b1, 1'b0, 1'b0, 1'b0, ~WIDTH'(i));
        // R5 read one full loop
        for (int i = 0; i < DEPTH; i++)
            cyc("R5 read", 1'b1, 1'b1, 1'b0, 1'b1, WIDTH'(i));
        // R2 idle again between passes
        for (int i = 0; i < 5; i++)
            cyc("R2 hold", 1'b0, 1'b0, 1'b0, 1'b0, 9'h0AA);
        // R7 read-modify-write with new bytes derived from the old ones
        for (int i = 0; i < DEPTH; i++)
            cyc("R7 rmw", 1'b1, 1'b1, 1'b0, 1'b0, model[sidx] ^ WIDTH'((i * 11 + 3) & 511));
        // R3 final read shows the modified contents
        for (int i = 0; i < DEPTH; i++)
            cyc("R3 readback", 1'b1, 1'b1, 1'b0, 1'b1, '0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule